// File: doc/BRIEF.md
# Tagged Translation Buffer with Swept Invalidation

This block is a small, fully associative translation buffer. Each slot holds a virtual page number, a page-size shift, a physical page number and a set of context tags: an address-space identifier, a virtual-machine identifier, a global flag, a non-secure tag, a hypervisor flag and the privilege level the slot was filled at. A lookup is combinational. It returns hit, the slot index and the translated physical address in the same cycle. A hit needs the page, the security world, the hypervisor regime, the VM identifier, the privilege regime and the address-space rule to agree.

Slots are filled in round-robin order. Maintenance commands remove slots selected by world, regime, address-space identifier or address. The block examines one slot per clock and pulses done when the pass is finished. A full flush is two passes, one over the non-secure world and one over the secure world. Some commands also request a flush of a second-stage buffer. That request is only a strobe on an output, because the second stage lives outside this block.

Top module: `tag_tlb`

## Requirements
- R1: A lookup hits slot i only if all of these hold: the slot is valid; (va >> shift) equals its page number; lk_secure equals the inverse of its non-secure tag; lk_hyp equals its hyp flag; and, for a non-secure lookup, its VM identifier equals lk_vmid (a secure lookup ignores the VM identifier). lk_pa is (ppn << shift) OR'd with the offset bits of va below shift. On several hits the lowest index is reported.
- R2: The regime rule uses levels encoded as 0..3. A target of 2 or 3 needs the stored level to equal the target. A target of 0 or 1 accepts a stored level of 0 or 1. Lookups and all commands apply this rule unless the rule is waived.
- R3: Unless lk_skip_asid is set, a hit also needs the slot to be global or its identifier to equal lk_asid.
- R4: A fill with fill_wide = 0 stores level 1, whatever fill_level is; with fill_wide = 1 it stores fill_level. Fills go to slots 0,1,2,... and wrap after the last slot.
- R5: Op 0 (all-in-world) clears every valid slot that meets three conditions: its world matches cmd_secure; its VM identifier equals cmd_vmid or the command is secure; and it passes the regime rule, unless cmd_skip_level is set.
- R6: Op 1 (all non-secure) clears every valid non-secure slot whose hyp flag equals (cmd_level == 2) and that passes the regime rule, unless cmd_skip_level is set.
- R7: Op 2 (by identifier) clears valid slots that meet all of these: the identifier equals cmd_asid; the world matches; the VM identifier matches or the command is secure; and the regime rule passes. cmd_skip_level has no effect on this op.
- R8: Op 3 (by address) clears valid slots whose page matches cmd_va under the slot's own shift, whose world matches, and that pass the regime rule. It also needs the slot to be global or its identifier to equal cmd_asid, unless cmd_skip_asid is set.
- R9: Op 4 (full flush) is op 0 for the non-secure world and then op 0 for the secure world, both at level 0 with the regime rule waived. Ops 5 to 7 are not accepted.
- R10: An accepted command holds cmd_busy for ENTRIES cycles per pass. cmd_done is then high for exactly one cycle, ENTRIES cycles after acceptance (2*ENTRIES for op 4). While busy, lookups miss and fills and new commands are dropped.
- R11: s2_flush pulses together with cmd_done after op 0 or op 4 when cmd_from_hyp is set, and after op 1 when cmd_level is not 2. With the pulse, s2_level is 1 and s2_skip_level is 1.
- R12: After reset, all slots are invalid, fills start at slot 0, and cmd_busy, cmd_done and s2_flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fill_en | input | 1 | Write a slot |
| fill_vpn | input | 48 | Page number (va >> shift) |
| fill_shift | input | 6 | Page-size shift |
| fill_ppn | input | 44 | Physical page number |
| fill_asid | input | 16 | Address-space identifier |
| fill_vmid | input | 8 | VM identifier |
| fill_global | input | 1 | Slot ignores identifier |
| fill_nonsec | input | 1 | Non-secure tag |
| fill_hyp | input | 1 | Hypervisor regime flag |
| fill_wide | input | 1 | Walk ran in 64-bit mode |
| fill_level | input | 2 | Current level |
| lk_va | input | 48 | Lookup address |
| lk_asid | input | 16 | Lookup identifier |
| lk_vmid | input | 8 | Lookup VM identifier |
| lk_secure | input | 1 | Lookup is secure |
| lk_hyp | input | 1 | Lookup is in hyp regime |
| lk_skip_asid | input | 1 | Waive identifier rule |
| lk_level | input | 2 | Target level |
| lk_hit | output | 1 | Lookup hit |
| lk_index | output | 3 | Hitting slot |
| lk_pa | output | 44 | Physical address |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code 0..4 |
| cmd_secure | input | 1 | Command world is secure |
| cmd_level | input | 2 | Target level |
| cmd_skip_level | input | 1 | Waive regime rule |
| cmd_skip_asid | input | 1 | Waive identifier rule (op 3) |
| cmd_asid | input | 16 | Identifier operand |
| cmd_vmid | input | 8 | Current VM identifier |
| cmd_va | input | 48 | Address operand |
| cmd_from_hyp | input | 1 | Issuer is first stage in hyp mode |
| cmd_busy | output | 1 | Sweep in progress |
| cmd_done | output | 1 | Sweep finished pulse |
| s2_flush | output | 1 | Second-stage flush request |
| s2_level | output | 2 | Level carried with the request |
| s2_skip_level | output | 1 | Regime waiver carried with the request |

## Verification
A wrong tag bit or a wrongly stored level shows at once as a wrong hit or miss on lk_hit, or a wrong lk_index, for the lookup that probes that slot. A sweep that clears too much or too little can only be seen afterwards. Lookups issued after cmd_done, aimed at a slot that should have survived and at one that should not, expose it within one cycle of done. A pointer or pass counter off by one moves cmd_done and s2_flush away from the expected cycle count, which is measured from acceptance.

// File: rtl/tlbt_pkg.sv
package tlbt_pkg;
  parameter int VA_W   = 48;
  parameter int PA_W   = 44;
  parameter int ASID_W = 16;
  parameter int VMID_W = 8;
  parameter int SH_W   = 6;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_t;

  typedef enum logic [2:0] {
    OP_ALL_SEC = 3'd0, OP_ALL_NS = 3'd1, OP_BY_ASID = 3'd2,
    OP_BY_ADDR = 3'd3, OP_FULL = 3'd4
  } op_t;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [SH_W-1:0]   shift;
    logic [PA_W-1:0]   ppn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              glob;
    logic              nonsec;
    logic              hyp;
    lvl_t              lvl;
  } tag_t;

  typedef struct packed {
    op_t               op;
    logic              secure;
    lvl_t              lvl;
    logic              skip_lvl;
    logic              skip_asid;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic [VA_W-1:0]   va;
    logic              from_hyp;
  } cmd_t;

  // EL2/EL3 exact; EL0/EL1 share a regime
  function automatic logic regime_ok(lvl_t target, lvl_t stored);
    if (target == LVL2 || target == LVL3) return stored == target;
    return (stored == LVL0) || (stored == LVL1);
  endfunction

  function automatic logic page_hit(logic [VA_W-1:0] va, logic [VA_W-1:0] vpn,
                                    logic [SH_W-1:0] shift);
    return (va >> shift) == vpn;
  endfunction

  function automatic logic world_ok(logic secure, logic nonsec);
    return secure == !nonsec;
  endfunction

  function automatic logic [PA_W-1:0] join_pa(logic [PA_W-1:0] ppn,
                                              logic [SH_W-1:0] shift,
                                              logic [VA_W-1:0] va);
    logic [PA_W-1:0] off_mask;
    off_mask = ~({PA_W{1'b1}} << shift);
    return (ppn << shift) | (PA_W'(va) & off_mask);
  endfunction
endpackage

// File: rtl/tlbt_entry_cmp.sv
module tlbt_entry_cmp
  import tlbt_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  tag_t              tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_secure,
  input  logic              lk_hyp,
  input  logic              lk_skip_asid,
  input  lvl_t              lk_level,
  output logic [ENTRIES-1:0] match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic ctx_ok, asid_ok;
    assign ctx_ok  = world_ok(lk_secure, tags[i].nonsec) && (lk_hyp == tags[i].hyp) &&
                     (lk_secure || (tags[i].vmid == lk_vmid));
    assign asid_ok = lk_skip_asid || tags[i].glob || (tags[i].asid == lk_asid);
    assign match[i] = valid[i] && page_hit(lk_va, tags[i].vpn, tags[i].shift) &&
                      ctx_ok && regime_ok(lk_level, tags[i].lvl) && asid_ok;
  end
endmodule

// File: rtl/tlbt_kill_eval.sv
module tlbt_kill_eval
  import tlbt_pkg::*;
(
  input  tag_t tag,
  input  logic valid,
  input  cmd_t cmd,
  input  logic pass,
  output logic kill
);
  logic sec_eff, skip_eff, lvl_pass, ctx_ok;
  lvl_t lvl_eff;

  always_comb begin
    // full flush: pass 0 non-secure, pass 1 secure, level 0, rule waived
    sec_eff  = (cmd.op == OP_FULL) ? pass : cmd.secure;
    lvl_eff  = (cmd.op == OP_FULL) ? LVL0 : cmd.lvl;
    skip_eff = (cmd.op == OP_FULL) ? 1'b1 : cmd.skip_lvl;
    lvl_pass = regime_ok(lvl_eff, tag.lvl);
    ctx_ok   = world_ok(sec_eff, tag.nonsec) && (sec_eff || (tag.vmid == cmd.vmid));
    kill     = 1'b0;
    unique case (cmd.op)
      OP_ALL_SEC, OP_FULL:
        kill = ctx_ok && (skip_eff || lvl_pass);
      OP_ALL_NS:
        kill = tag.nonsec && (tag.hyp == (cmd.lvl == LVL2)) && (skip_eff || lvl_pass);
      OP_BY_ASID:
        kill = (tag.asid == cmd.asid) && ctx_ok && lvl_pass;
      OP_BY_ADDR:
        kill = page_hit(cmd.va, tag.vpn, tag.shift) && world_ok(sec_eff, tag.nonsec) &&
               lvl_pass && (cmd.skip_asid || tag.glob || (tag.asid == cmd.asid));
      default: kill = 1'b0;
    endcase
    kill = kill && valid;
  end
endmodule

// File: rtl/tlbt_sweep.sv
module tlbt_sweep
  import tlbt_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       req_op,
  input  cmd_t             req_cmd,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             pass,
  output cmd_t             cur,
  output logic             done,
  output logic             s2_req
);
  logic accept, last_slot, last_pass, want_s2;

  assign accept    = req && !busy && (req_op <= 3'd4);
  assign last_slot = (idx == IDX_W'(ENTRIES - 1));
  assign last_pass = (cur.op != OP_FULL) || pass;

  always_comb begin
    unique case (cur.op)
      OP_ALL_SEC, OP_FULL: want_s2 = cur.from_hyp;
      OP_ALL_NS:           want_s2 = (cur.lvl != LVL2);
      default:             want_s2 = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      pass   <= 1'b0;
      cur    <= '0;
      done   <= 1'b0;
      s2_req <= 1'b0;
    end else begin
      done   <= 1'b0;
      s2_req <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
        pass <= 1'b0;
        cur  <= req_cmd;
      end else if (busy) begin
        if (last_slot) begin
          idx <= '0;
          if (last_pass) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            s2_req <= want_s2;
          end else begin
            pass <= 1'b1;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_S2_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    s2_req |-> done); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(last_slot && last_pass)) |=> (busy && $stable(cur))); // R10
endmodule

// File: rtl/tag_tlb.sv
module tag_tlb
  import tlbt_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill_en,
  input  logic [VA_W-1:0]            fill_vpn,
  input  logic [SH_W-1:0]            fill_shift,
  input  logic [PA_W-1:0]            fill_ppn,
  input  logic [ASID_W-1:0]          fill_asid,
  input  logic [VMID_W-1:0]          fill_vmid,
  input  logic                       fill_global,
  input  logic                       fill_nonsec,
  input  logic                       fill_hyp,
  input  logic                       fill_wide,
  input  logic [1:0]                 fill_level,
  input  logic [VA_W-1:0]            lk_va,
  input  logic [ASID_W-1:0]          lk_asid,
  input  logic [VMID_W-1:0]          lk_vmid,
  input  logic                       lk_secure,
  input  logic                       lk_hyp,
  input  logic                       lk_skip_asid,
  input  logic [1:0]                 lk_level,
  output logic                       lk_hit,
  output logic [$clog2(ENTRIES)-1:0] lk_index,
  output logic [PA_W-1:0]            lk_pa,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic                       cmd_secure,
  input  logic [1:0]                 cmd_level,
  input  logic                       cmd_skip_level,
  input  logic                       cmd_skip_asid,
  input  logic [ASID_W-1:0]          cmd_asid,
  input  logic [VMID_W-1:0]          cmd_vmid,
  input  logic [VA_W-1:0]            cmd_va,
  input  logic                       cmd_from_hyp,
  output logic                       cmd_busy,
  output logic                       cmd_done,
  output logic                       s2_flush,
  output logic [1:0]                 s2_level,
  output logic                       s2_skip_level
);
  localparam int IDX_W = $clog2(ENTRIES);

  tag_t               tags [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] match;
  logic               fill_take;
  tag_t               fill_tag;
  cmd_t               req_cmd, cur_cmd;
  logic [IDX_W-1:0]   sw_idx;
  logic               sw_pass, sw_kill, kill_raw;

  // ---- fill path ----
  assign fill_take = fill_en && !cmd_busy;

  always_comb begin
    fill_tag.vpn    = fill_vpn;
    fill_tag.shift  = fill_shift;
    fill_tag.ppn    = fill_ppn;
    fill_tag.asid   = fill_asid;
    fill_tag.vmid   = fill_vmid;
    fill_tag.glob   = fill_global;
    fill_tag.nonsec = fill_nonsec;
    fill_tag.hyp    = fill_hyp;
    fill_tag.lvl    = fill_wide ? lvl_t'(fill_level) : LVL1;
  end

  always_ff @(posedge clk) begin
    if (fill_take) tags[rr_q] <= fill_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      if (fill_take) begin
        valid_q[rr_q] <= 1'b1;
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
      if (sw_kill) valid_q[sw_idx] <= 1'b0;
    end
  end

  // ---- lookup path ----
  tlbt_entry_cmp #(.ENTRIES(ENTRIES)) u_cmp (
    .tags(tags), .valid(valid_q), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_vmid(lk_vmid), .lk_secure(lk_secure), .lk_hyp(lk_hyp),
    .lk_skip_asid(lk_skip_asid), .lk_level(lvl_t'(lk_level)), .match(match)
  );

  always_comb begin
    lk_index = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) lk_index = IDX_W'(i);
    end
    lk_hit = (|match) && !cmd_busy;
    lk_pa  = join_pa(tags[lk_index].ppn, tags[lk_index].shift, lk_va);
  end

  // ---- command path ----
  always_comb begin
    req_cmd.op        = op_t'(cmd_op);
    req_cmd.secure    = cmd_secure;
    req_cmd.lvl       = lvl_t'(cmd_level);
    req_cmd.skip_lvl  = cmd_skip_level;
    req_cmd.skip_asid = cmd_skip_asid;
    req_cmd.asid      = cmd_asid;
    req_cmd.vmid      = cmd_vmid;
    req_cmd.va        = cmd_va;
    req_cmd.from_hyp  = cmd_from_hyp;
  end

  tlbt_sweep #(.ENTRIES(ENTRIES)) u_sweep (
    .clk(clk), .rst_n(rst_n), .req(cmd_valid), .req_op(cmd_op), .req_cmd(req_cmd),
    .busy(cmd_busy), .idx(sw_idx), .pass(sw_pass), .cur(cur_cmd),
    .done(cmd_done), .s2_req(s2_flush)
  );

  tlbt_kill_eval u_kill (
    .tag(tags[sw_idx]), .valid(valid_q[sw_idx]), .cmd(cur_cmd),
    .pass(sw_pass), .kill(kill_raw)
  );

  assign sw_kill       = cmd_busy && kill_raw;
  assign s2_level      = s2_flush ? 2'd1 : 2'd0;
  assign s2_skip_level = s2_flush;

  AST_MISS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !lk_hit); // R10
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_kill |=> !valid_q[$past(sw_idx)]); // R5
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_take |=> valid_q[$past(rr_q)]); // R4
  AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_q[lk_index]); // R1
  AST_S2_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    s2_flush |-> (s2_level == 2'd1 && s2_skip_level)); // R11
endmodule

// File: tb/tag_tlb_test.sv
module tag_tlb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic fill_en = 0, fill_global = 0, fill_nonsec = 0, fill_hyp = 0, fill_wide = 0;
  logic [47:0] fill_vpn = 0; logic [5:0] fill_shift = 0; logic [43:0] fill_ppn = 0;
  logic [15:0] fill_asid = 0; logic [7:0] fill_vmid = 0; logic [1:0] fill_level = 0;
  logic [47:0] lk_va = 0; logic [15:0] lk_asid = 0; logic [7:0] lk_vmid = 0;
  logic lk_secure = 0, lk_hyp = 0, lk_skip_asid = 0; logic [1:0] lk_level = 0;
  logic lk_hit; logic [2:0] lk_index; logic [43:0] lk_pa;
  logic cmd_valid = 0, cmd_secure = 0, cmd_skip_level = 0, cmd_skip_asid = 0, cmd_from_hyp = 0;
  logic [2:0] cmd_op = 0; logic [1:0] cmd_level = 0; logic [15:0] cmd_asid = 0;
  logic [7:0] cmd_vmid = 0; logic [47:0] cmd_va = 0;
  logic cmd_busy, cmd_done, s2_flush, s2_skip_level; logic [1:0] s2_level;

  int total = 0, bad = 0;

  tag_tlb uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(logic [47:0] vpn, logic [5:0] sh, logic [43:0] ppn, logic [15:0] asid,
                      logic [7:0] vmid, logic g, logic ns, logic hy, logic wide, logic [1:0] lv);
    @(negedge clk);
    fill_vpn = vpn; fill_shift = sh; fill_ppn = ppn; fill_asid = asid; fill_vmid = vmid;
    fill_global = g; fill_nonsec = ns; fill_hyp = hy; fill_wide = wide; fill_level = lv;
    fill_en = 1;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(logic [47:0] va, logic [15:0] asid, logic [7:0] vmid, logic sec,
                      logic hy, logic na, logic [1:0] lv);
    lk_va = va; lk_asid = asid; lk_vmid = vmid; lk_secure = sec; lk_hyp = hy;
    lk_skip_asid = na; lk_level = lv;
    #2;
  endtask

  task automatic run_cmd(logic [2:0] op, logic sec, logic [1:0] lv, logic skl, logic ska,
                         logic [15:0] asid, logic [7:0] vmid, logic [47:0] va, logic fh,
                         int exp_cyc, logic exp_s2, string req);
    int cyc;
    @(negedge clk);
    cmd_op = op; cmd_secure = sec; cmd_level = lv; cmd_skip_level = skl; cmd_skip_asid = ska;
    cmd_asid = asid; cmd_vmid = vmid; cmd_va = va; cmd_from_hyp = fh; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cmd_done && cyc < 40);
    check({req, " sweep length"}, 64'(cyc), 64'(exp_cyc));
    check({req, " s2 flush"}, {63'd0, s2_flush}, {63'd0, exp_s2});
    if (exp_s2) check({req, " s2 level/skip"}, {61'd0, s2_level, s2_skip_level}, 64'h3);
  endtask

  typedef struct packed {
    logic [47:0] va; logic [15:0] asid; logic [7:0] vmid;
    logic sec; logic hy; logic na; logic [1:0] lv;
    logic hit; logic [2:0] idx; logic [43:0] pa; logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{48'h100123, 16'd5, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 3'd0, 44'h500123, 4'd1}, // R1
    '{48'h100123, 16'd6, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 44'h0,      4'd3}, // R3
    '{48'h100123, 16'd6, 8'd1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 3'd0, 44'h500123, 4'd3}, // R3
    '{48'h100123, 16'd5, 8'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 3'd0, 44'h500123, 4'd2}, // R2
    '{48'h100123, 16'd5, 8'd1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 3'd0, 44'h0,      4'd2}, // R2
    '{48'h200abc, 16'd9, 8'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 3'd1, 44'h600abc, 4'd4}, // R4
    '{48'h300010, 16'd5, 8'd9, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 3'd2, 44'h700010, 4'd1}, // R1
    '{48'h300010, 16'd5, 8'd2, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 3'd0, 44'h0,      4'd1}, // R1
    '{48'h400020, 16'd1, 8'd1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 3'd3, 44'h800020, 4'd1}, // R1
    '{48'h400020, 16'd1, 8'd1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 3'd0, 44'h0,      4'd1}, // R1
    '{48'hA12345, 16'd9, 8'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 3'd4, 44'h1212345, 4'd1}, // R1
    '{48'h600000, 16'd5, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 44'h0,      4'd1}, // R1
    '{48'h101000, 16'd5, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 44'h0,      4'd1}, // R1
    '{48'h100fff, 16'd5, 8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 3'd0, 44'h500fff, 4'd1}  // R1
  };

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 busy", {63'd0, cmd_busy}, 0);
    check("R12 done", {63'd0, cmd_done}, 0);
    check("R12 s2", {63'd0, s2_flush}, 0);
    look(48'h100123, 16'd5, 8'd1, 0, 0, 0, 2'd0);
    check("R12 empty miss", {63'd0, lk_hit}, 0);

    // R4: fills land in slots 0..7
    fill(48'h100, 12, 44'h500, 5, 1, 0, 1, 0, 1, 0);
    fill(48'h200, 12, 44'h600, 7, 1, 1, 1, 0, 0, 3); // 32-bit walk stores level 1
    fill(48'h300, 12, 44'h700, 5, 2, 0, 0, 0, 1, 3);
    fill(48'h400, 12, 44'h800, 0, 1, 1, 1, 1, 1, 2);
    fill(48'h5,   21, 44'h9,   9, 1, 0, 1, 0, 1, 1);
    fill(48'h600, 12, 44'hA00, 5, 3, 0, 1, 0, 1, 0);
    fill(48'h700, 12, 44'hB00, 5, 1, 0, 0, 0, 1, 1);
    fill(48'h800, 12, 44'hC00, 6, 1, 0, 1, 0, 1, 0);

    // R1 R2 R3 R4: lookup table
    foreach (VECS[k]) begin
      @(negedge clk);
      look(VECS[k].va, VECS[k].asid, VECS[k].vmid, VECS[k].sec, VECS[k].hy, VECS[k].na, VECS[k].lv);
      check($sformatf("R%0d lookup hit vec %0d", VECS[k].req, k), {63'd0, lk_hit}, {63'd0, VECS[k].hit});
      if (VECS[k].hit) begin
        check($sformatf("R%0d lookup index vec %0d", VECS[k].req, k), 64'(lk_index), 64'(VECS[k].idx));
        check($sformatf("R%0d lookup pa vec %0d", VECS[k].req, k), 64'(lk_pa), 64'(VECS[k].pa));
      end
    end

    // R10: busy window, miss while busy, fill dropped, done single pulse
    begin
      int cyc;
      @(negedge clk);
      look(48'h100123, 16'd5, 8'd1, 0, 0, 0, 2'd0);
      cmd_op = 3'd2; cmd_secure = 0; cmd_level = 0; cmd_skip_level = 0; cmd_asid = 16'd99;
      cmd_vmid = 8'd1; cmd_from_hyp = 0; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
      check("R10 busy after accept", {63'd0, cmd_busy}, 1);
      check("R10 miss while busy", {63'd0, lk_hit}, 0);
      fill_vpn = 48'h900; fill_shift = 12; fill_ppn = 44'hD00; fill_asid = 1; fill_vmid = 4;
      fill_global = 0; fill_nonsec = 1; fill_hyp = 0; fill_wide = 1; fill_level = 0; fill_en = 1;
      cyc = 0;
      do begin
        @(negedge clk);
        fill_en = 0;
        cyc++;
      end while (!cmd_done && cyc < 40);
      check("R10 sweep length", 64'(cyc), 64'd8);
      check("R10 no s2 for by-identifier", {63'd0, s2_flush}, 0);
      check("R10 hit after sweep", {63'd0, lk_hit}, 1);
      @(negedge clk);
      check("R10 done one cycle", {63'd0, cmd_done}, 0);
      look(48'h900abc, 16'd1, 8'd4, 0, 0, 0, 2'd0);
      check("R10 fill dropped while busy", {63'd0, lk_hit}, 0);
    end

    // R8: by address, identifier rule then waived
    run_cmd(3'd3, 0, 2'd0, 0, 0, 16'd6, 8'd1, 48'h100000, 0, 8, 0, "R8");
    look(48'h100123, 16'd5, 8'd1, 0, 0, 0, 2'd0);
    check("R8 other identifier kept", {63'd0, lk_hit}, 1);
    run_cmd(3'd3, 0, 2'd0, 0, 1, 16'd6, 8'd1, 48'h100000, 0, 8, 0, "R8");
    look(48'h100123, 16'd5, 8'd1, 0, 0, 0, 2'd0);
    check("R8 waived identifier cleared", {63'd0, lk_hit}, 0);

    // R7: skip-level ignored by identifier op
    run_cmd(3'd2, 0, 2'd2, 1, 0, 16'd6, 8'd1, 48'h0, 0, 8, 0, "R7");
    look(48'h800000, 16'd6, 8'd1, 0, 0, 0, 2'd0);
    check("R7 regime still applied", {63'd0, lk_hit}, 1);
    run_cmd(3'd2, 0, 2'd0, 0, 0, 16'd6, 8'd1, 48'h0, 0, 8, 0, "R7");
    look(48'h800000, 16'd6, 8'd1, 0, 0, 0, 2'd0);
    check("R7 identifier cleared", {63'd0, lk_hit}, 0);

    // R6 R11: all non-secure, hyp target, no stage-2 strobe
    run_cmd(3'd1, 0, 2'd2, 0, 0, 16'd0, 8'd1, 48'h0, 0, 8, 0, "R6 R11");
    look(48'h400020, 16'd1, 8'd1, 0, 1, 0, 2'd2);
    check("R6 hyp slot cleared", {63'd0, lk_hit}, 0);
    look(48'h200abc, 16'd9, 8'd1, 0, 0, 0, 2'd1);
    check("R6 non-hyp slot kept", {63'd0, lk_hit}, 1);

    // R5 R11: secure world, level 1, from hyp issuer
    run_cmd(3'd0, 1, 2'd1, 0, 0, 16'd0, 8'd1, 48'h0, 1, 8, 1, "R5 R11");
    look(48'h700000, 16'd5, 8'd1, 1, 0, 0, 2'd1);
    check("R5 secure level-1 slot cleared", {63'd0, lk_hit}, 0);
    look(48'h300010, 16'd5, 8'd9, 1, 0, 0, 2'd3);
    check("R5 secure level-3 slot kept", {63'd0, lk_hit}, 1);

    // R6 R11: all non-secure, non-hyp target, ignores VM identifier
    run_cmd(3'd1, 0, 2'd1, 0, 0, 16'd0, 8'd1, 48'h0, 0, 8, 1, "R6 R11");
    look(48'h200abc, 16'd9, 8'd1, 0, 0, 0, 2'd1);
    check("R6 level-1 slot cleared", {63'd0, lk_hit}, 0);
    look(48'h600000, 16'd5, 8'd3, 0, 0, 0, 2'd0);
    check("R6 other VM cleared", {63'd0, lk_hit}, 0);

    // R4: wrap to slot 0
    fill(48'h900, 12, 44'hD00, 1, 4, 0, 1, 0, 1, 0);
    look(48'h900abc, 16'd1, 8'd4, 0, 0, 0, 2'd0);
    check("R4 wrap hit", {63'd0, lk_hit}, 1);
    check("R4 wrap index", 64'(lk_index), 0);
    check("R4 wrap pa", 64'(lk_pa), 64'hD00abc);

    // R9: full flush, two passes, non-secure pass keyed to current VM
    run_cmd(3'd4, 0, 2'd3, 0, 0, 16'd0, 8'd1, 48'h0, 0, 16, 0, "R9");
    look(48'h300010, 16'd5, 8'd9, 1, 0, 0, 2'd3);
    check("R9 secure slot cleared", {63'd0, lk_hit}, 0);
    look(48'h900abc, 16'd1, 8'd4, 0, 0, 0, 2'd0);
    check("R9 other VM survives", {63'd0, lk_hit}, 1);
    run_cmd(3'd4, 0, 2'd3, 0, 0, 16'd0, 8'd4, 48'h0, 1, 16, 1, "R9 R11");
    look(48'h900abc, 16'd1, 8'd4, 0, 0, 0, 2'd0);
    check("R9 matching VM cleared", {63'd0, lk_hit}, 0);

    // R9: illegal op not accepted
    @(negedge clk);
    cmd_op = 3'd6; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    check("R9 op 6 ignored", {63'd0, cmd_busy}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule